// File: doc/BRIEF.md
# Bus Trigger Resource Matcher

This block watches a processor's sampled address, data and status buses and decides on which sample a capture trigger fires. It holds four programmable compare resources. Each one reads a single bus and checks it for equality, for greater-or-equal or for less-or-equal against a programmed value. A per-bit don't-care mask takes chosen bits out of the compare, and an invert bit negates the result. A range check uses two resources, one for each bound, joined by AND. The four resource outputs index a 16-entry truth table, so any AND, OR or NOT function of them can be programmed.

An occurrence counter holds the trigger off until the combined condition has been seen on a preset number of valid samples. This lets the trigger land on the Nth pass of a loop. The trigger is a one-cycle pulse. After it fires, the block stays silent until a rearm strobe clears the count and the fired state.

Samples arrive on a valid/ready stream. Observation is passive, so the block never applies back-pressure: `smp_ready` is high whenever reset is released, and every beat with `smp_valid` high is accepted. Configuration goes through a plain register write port.

Top module: `bus_trigger_matcher`

## Requirements
- R1: Out of reset, `trig` is low and the truth table is all zero, so no sample fires a trigger until the block is configured.
- R2: A resource in equal mode (mode code 0 or 3 in control bits [3:2]) matches when every bit whose mask bit is 0 equals the programmed value. Bits whose mask bit is 1 are ignored.
- R3: Setting the invert bit (control bit 4) negates a resource's compare result.
- R4: Mode 1 matches when the masked bus is greater than or equal to the masked value. Mode 2 matches when it is less than or equal. Both bounds are inclusive, and the complemented truth table gives a trigger outside the range.
- R5: Control bits [1:0] select the bus: 0 selects address, 1 selects data, 2 selects status (zero-extended to 32 bits). Code 3 forces the resource output to 0, whatever the invert bit holds.
- R6: The combined condition is truth-table bit number {r3,r2,r1,r0}, where rN is the output of resource N.
- R7: A sample with `smp_valid` low is never counted and never fires a trigger.
- R8: Each valid sample that meets the combined condition adds one to a 16-bit saturating count. The trigger fires on the sample that brings the count to the preset. A preset of 0 or 1 fires on the first such sample.
- R9: `trig` is high for exactly one cycle, in the cycle after the sample that fires it. No further trigger fires until a rearm.
- R10: `rearm` clears the count and the fired state. A sample presented in the same cycle as the rearm is not counted.
- R11: The register map is: resource N uses value at address 4N, mask at 4N+1 and control at 4N+2; the truth table is at 16 and the preset at 17. A write takes effect for the sample presented in the next cycle.
- R12: `smp_ready` is high whenever reset is not asserted.

Only the low 16 bits of the write data are used for the truth table and the preset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 5 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| smp_valid | input | 1 | Sample beat valid |
| smp_ready | output | 1 | Sample beat accepted (never stalls) |
| smp_addr | input | 32 | Sampled address bus |
| smp_data | input | 32 | Sampled data bus |
| smp_stat | input | 8 | Sampled status bus |
| rearm | input | 1 | Clears the count and the fired state |
| trig | output | 1 | One-cycle trigger pulse |

## Verification
The bench drives each range bound exactly, together with the values one below and one above. A design with an off-by-one or a strict compare would drop a bound or accept a neighbour. It also checks that a preset of 3 fires on the third qualified sample and no other, and that a preset of 0 fires at once. A counter that fires early, fires late or refires would show up there. A sample presented together with a rearm must not be counted, or the next trigger would come one sample early. Randomized configurations, including the disabled bus select with invert set, are checked against a bench model. They catch a wrong truth-table bit order or mask polarity.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int RES_W = 32;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_DATA = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } bus_sel_e;

  typedef enum logic [1:0] {
    CMP_EQ  = 2'd0,
    CMP_GE  = 2'd1,
    CMP_LE  = 2'd2,
    CMP_EQX = 2'd3
  } cmp_mode_e;

  typedef struct packed {
    logic [RES_W-1:0] value;
    logic [RES_W-1:0] mask;
    bus_sel_e         sel;
    cmp_mode_e        mode;
    logic             inv;
  } res_cfg_t;
endpackage

// File: rtl/trig_resource.sv
module trig_resource
  import trig_pkg::*;
(
  input  res_cfg_t         cfg,
  input  logic [RES_W-1:0] bus_a,
  input  logic [RES_W-1:0] bus_d,
  input  logic [RES_W-1:0] bus_s,
  output logic             hit
);
  logic [RES_W-1:0] bus, care, bus_m, val_m;
  logic             enabled, raw;

  always_comb begin
    enabled = 1'b1;
    case (cfg.sel)
      SEL_ADDR: bus = bus_a;
      SEL_DATA: bus = bus_d;
      SEL_STAT: bus = bus_s;
      default: begin
        bus     = '0;
        enabled = 1'b0;
      end
    endcase
    care  = ~cfg.mask;
    bus_m = bus & care;
    val_m = cfg.value & care;
    case (cfg.mode)
      CMP_GE:  raw = (bus_m >= val_m);
      CMP_LE:  raw = (bus_m <= val_m);
      default: raw = (bus_m == val_m);
    endcase
    hit = enabled & (raw ^ cfg.inv);
  end
endmodule

// File: rtl/trig_combiner.sv
module trig_combiner #(
  parameter int NUM_RES = 4,
  localparam int TT_W = 1 << NUM_RES
) (
  input  logic [NUM_RES-1:0] hits,
  input  logic [TT_W-1:0]    table_bits,
  output logic               cond
);
  assign cond = table_bits[hits];
endmodule

// File: rtl/trig_occurrence.sv
module trig_occurrence #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             qual,
  input  logic             rearm,
  input  logic [CNT_W-1:0] preset,
  output logic             trig
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt, cnt_nx, thr;
  logic             fired;

  assign cnt_nx = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
  assign thr    = (preset == '0) ? CNT_W'(1) : preset;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      fired <= 1'b0;
      trig  <= 1'b0;
    end else if (rearm) begin
      cnt   <= '0;
      fired <= 1'b0;
      trig  <= 1'b0;
    end else begin
      trig <= 1'b0;
      if (qual && !fired) begin
        cnt <= cnt_nx;
        if (cnt_nx >= thr) begin
          trig  <= 1'b1;
          fired <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bus_trigger_matcher.sv
module bus_trigger_matcher
  import trig_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int STAT_W  = 8,
  parameter int NUM_RES = 4,
  parameter int CNT_W   = 16,
  localparam int TT_W   = 1 << NUM_RES,
  localparam int CFG_AW = $clog2(NUM_RES * 4 + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [RES_W-1:0]  cfg_wdata,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [ADDR_W-1:0] smp_addr,
  input  logic [DATA_W-1:0] smp_data,
  input  logic [STAT_W-1:0] smp_stat,
  input  logic              rearm,
  output logic              trig
);
  localparam int TT_ADDR  = NUM_RES * 4;
  localparam int PRE_ADDR = NUM_RES * 4 + 1;

  res_cfg_t         rcfg [NUM_RES];
  logic [TT_W-1:0]  tt;
  logic [CNT_W-1:0] preset;
  logic [NUM_RES-1:0] hits;
  logic             cond;
  logic [RES_W-1:0] a_ext, d_ext, s_ext;

  assign smp_ready = rst_n;
  assign a_ext = RES_W'(smp_addr);
  assign d_ext = RES_W'(smp_data);
  assign s_ext = RES_W'(smp_stat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_RES; i++) rcfg[i] <= '0;
      tt     <= '0;
      preset <= '0;
    end else if (cfg_we) begin
      for (int i = 0; i < NUM_RES; i++) begin
        if (int'(cfg_addr) == i * 4)     rcfg[i].value <= cfg_wdata;
        if (int'(cfg_addr) == i * 4 + 1) rcfg[i].mask  <= cfg_wdata;
        if (int'(cfg_addr) == i * 4 + 2) begin
          rcfg[i].sel  <= bus_sel_e'(cfg_wdata[1:0]);
          rcfg[i].mode <= cmp_mode_e'(cfg_wdata[3:2]);
          rcfg[i].inv  <= cfg_wdata[4];
        end
      end
      if (int'(cfg_addr) == TT_ADDR)  tt     <= TT_W'(cfg_wdata);
      if (int'(cfg_addr) == PRE_ADDR) preset <= CNT_W'(cfg_wdata);
    end
  end

  for (genvar g = 0; g < NUM_RES; g++) begin : g_res
    trig_resource u_res (
      .cfg   (rcfg[g]),
      .bus_a (a_ext),
      .bus_d (d_ext),
      .bus_s (s_ext),
      .hit   (hits[g])
    );
  end

  trig_combiner #(.NUM_RES(NUM_RES)) u_comb (
    .hits       (hits),
    .table_bits (tt),
    .cond       (cond)
  );

  trig_occurrence #(.CNT_W(CNT_W)) u_occ (
    .clk    (clk),
    .rst_n  (rst_n),
    .qual   (smp_valid & cond),
    .rearm  (rearm),
    .preset (preset),
    .trig   (trig)
  );
endmodule

// File: rtl/bus_trigger_matcher_chk.sv
module bus_trigger_matcher_chk (
  input logic clk,
  input logic rst_n,
  input logic smp_valid,
  input logic rearm,
  input logic trig
);
  logic seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     seen <= 1'b0;
    else if (rearm) seen <= 1'b0;
    else if (trig)  seen <= 1'b1;
  end

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);

  a_r9_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !rearm) |=> !trig);

  a_r7_valid_needed: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> $past(smp_valid));

  a_r10_rearm_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> !trig);
endmodule

bind bus_trigger_matcher bus_trigger_matcher_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_valid (smp_valid),
  .rearm     (rearm),
  .trig      (trig)
);

// File: tb/bus_trigger_matcher_test.sv
`timescale 1ns/1ps
module bus_trigger_matcher_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [31:0] smp_addr = '0;
  logic [31:0] smp_data = '0;
  logic [7:0]  smp_stat = '0;
  logic        rearm = 1'b0;
  logic        trig;

  int checks = 0;
  int errors = 0;

  bit [31:0] s_val [4];
  bit [31:0] s_mask [4];
  bit [1:0]  s_sel [4];
  bit [1:0]  s_mode [4];
  bit        s_inv [4];
  bit [15:0] s_tt, s_pre;
  bit [15:0] m_cnt;
  bit        m_fired;

  always #5 clk = ~clk;

  bus_trigger_matcher uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_addr(smp_addr), .smp_data(smp_data), .smp_stat(smp_stat),
    .rearm(rearm), .trig(trig)
  );

  task automatic check(bit ok, string req, logic act, logic exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit mhit(int i, bit [31:0] a, bit [31:0] d, bit [7:0] s);
    bit [31:0] b, c;
    bit r;
    case (s_sel[i])
      2'd0: b = a;
      2'd1: b = d;
      2'd2: b = {24'h0, s};
      default: return 1'b0;
    endcase
    c = ~s_mask[i];
    case (s_mode[i])
      2'd1: r = (b & c) >= (s_val[i] & c);
      2'd2: r = (b & c) <= (s_val[i] & c);
      default: r = ((b ^ s_val[i]) & c) == 0;
    endcase
    return r ^ s_inv[i];
  endfunction

  task automatic wr(int a, bit [31:0] d);
    cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = d;
    smp_valid = 1'b0; rearm = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a == 16) s_tt = d[15:0];
    else if (a == 17) s_pre = d[15:0];
    else if (a % 4 == 0) s_val[a/4] = d;
    else if (a % 4 == 1) s_mask[a/4] = d;
    else if (a % 4 == 2) begin
      s_sel[a/4] = d[1:0]; s_mode[a/4] = d[3:2]; s_inv[a/4] = d[4];
    end
  endtask

  task automatic set_res(int i, bit [31:0] v, bit [31:0] m, bit [1:0] sel, bit [1:0] mode, bit inv);
    wr(i*4, v);
    wr(i*4+1, m);
    wr(i*4+2, {27'h0, inv, mode, sel});
  endtask

  task automatic cyc(bit v, bit [31:0] a, bit [31:0] d, bit [7:0] s, bit rr, string req);
    bit exp;
    bit [3:0] idx;
    bit [15:0] nx, thr;
    smp_valid = v; smp_addr = a; smp_data = d; smp_stat = s; rearm = rr;
    exp = 1'b0;
    if (rr) begin
      m_cnt = 0; m_fired = 0;
    end else begin
      for (int i = 0; i < 4; i++) idx[i] = mhit(i, a, d, s);
      if (v && s_tt[idx] && !m_fired) begin
        nx = (m_cnt == 16'hFFFF) ? m_cnt : m_cnt + 1;
        m_cnt = nx;
        thr = (s_pre == 0) ? 16'd1 : s_pre;
        if (nx >= thr) begin exp = 1'b1; m_fired = 1'b1; end
      end
    end
    @(negedge clk);
    check(trig === exp, req, trig, exp);
    smp_valid = 1'b0; rearm = 1'b0;
  endtask

  task automatic addr_hit(bit [31:0] a, string req);
    cyc(1'b0, 0, 0, 0, 1'b1, "R10");
    cyc(1'b1, a, 0, 0, 1'b0, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit [31:0] pool [8];
    for (int i = 0; i < 4; i++) begin
      s_val[i] = 0; s_mask[i] = 0; s_sel[i] = 0; s_mode[i] = 0; s_inv[i] = 0;
    end
    s_tt = 0; s_pre = 0; m_cnt = 0; m_fired = 0;
    repeat (3) @(negedge clk);
    check(trig === 1'b0, "R1", trig, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check(smp_ready === 1'b1, "R12", smp_ready, 1'b1);
    // R1: unconfigured table never fires
    cyc(1'b1, 0, 0, 0, 1'b0, "R1");
    cyc(1'b1, 32'hFFFF_FFFF, 5, 1, 1'b0, "R1");

    // R2 and R11: masked equality on address, used right after the write
    set_res(0, 32'h5000_0000, 32'h000F_FFFF, 2'd0, 2'd0, 1'b0);
    wr(16, 32'hAAAA);
    cyc(1'b1, 32'h500A_BCDE, 0, 0, 1'b0, "R11");
    addr_hit(32'h510A_BCDE, "R2");
    addr_hit(32'h500F_FFFF, "R2");

    // R3: inverted equality
    set_res(0, 32'h1234, 0, 2'd0, 2'd3, 1'b1);
    addr_hit(32'h1234, "R3");
    addr_hit(32'h1235, "R3");

    // R4: inclusive range built from two resources
    set_res(0, 32'h5000_0000, 0, 2'd0, 2'd1, 1'b0);
    set_res(1, 32'h5000_0010, 0, 2'd0, 2'd2, 1'b0);
    wr(16, 32'h8888);
    addr_hit(32'h5000_0000, "R4");
    addr_hit(32'h5000_0010, "R4");
    addr_hit(32'h4FFF_FFFF, "R4");
    addr_hit(32'h5000_0011, "R4");
    wr(16, 32'h7777);
    addr_hit(32'h4FFF_FFFF, "R4");
    addr_hit(32'h5000_0008, "R4");

    // R5 and R6: address AND data AND status
    set_res(0, 32'hAAAA_AAAA, 0, 2'd0, 2'd0, 1'b0);
    set_res(1, 32'h34, 0, 2'd1, 2'd0, 1'b0);
    set_res(2, 32'h02, 0, 2'd2, 2'd0, 1'b0);
    set_res(3, 0, 0, 2'd3, 2'd0, 1'b1);
    wr(16, 32'h8080);
    cyc(1'b0, 0, 0, 0, 1'b1, "R10");
    cyc(1'b1, 32'hAAAA_AAAA, 32'h34, 8'h01, 1'b0, "R5");
    cyc(1'b1, 32'hAAAA_AAAA, 32'h34, 8'h02, 1'b0, "R5");
    wr(16, 32'hFF00);
    cyc(1'b0, 0, 0, 0, 1'b1, "R10");
    cyc(1'b1, 0, 0, 0, 1'b0, "R5");
    wr(16, 32'h0020);
    cyc(1'b1, 32'hAAAA_AAAA, 32'h35, 8'h02, 1'b0, "R6");
    cyc(1'b1, 32'hAAAA_AAAA, 32'h34, 8'h02, 1'b0, "R6");

    // R7, R8, R9, R10: counting with preset 3
    set_res(0, 32'h40, 0, 2'd0, 2'd0, 1'b0);
    wr(16, 32'hAAAA);
    wr(17, 3);
    cyc(1'b0, 0, 0, 0, 1'b1, "R10");
    cyc(1'b0, 32'h40, 0, 0, 1'b0, "R7");
    cyc(1'b1, 32'h40, 0, 0, 1'b0, "R8");
    cyc(1'b1, 32'h41, 0, 0, 1'b0, "R8");
    cyc(1'b1, 32'h40, 0, 0, 1'b0, "R8");
    cyc(1'b0, 32'h40, 0, 0, 1'b0, "R7");
    cyc(1'b1, 32'h40, 0, 0, 1'b0, "R8");
    cyc(1'b1, 32'h40, 0, 0, 1'b0, "R9");
    cyc(1'b1, 32'h40, 0, 0, 1'b0, "R9");
    wr(17, 2);
    cyc(1'b1, 32'h40, 0, 0, 1'b1, "R10");
    cyc(1'b1, 32'h40, 0, 0, 1'b0, "R10");
    cyc(1'b1, 32'h40, 0, 0, 1'b0, "R10");
    wr(17, 0);
    addr_hit(32'h40, "R8");

    // Randomized configurations against the bench model
    void'($urandom(32'h1234_5678));
    for (int rnd = 0; rnd < 24; rnd++) begin
      for (int i = 0; i < 4; i++) begin
        bit [31:0] mk;
        mk = ($urandom % 2) ? 32'h0 : ($urandom & 32'h0000_0FFF);
        set_res(i, $urandom & 32'h0000_00FF, mk, 2'($urandom), 2'($urandom), 1'($urandom));
        pool[i] = s_val[i];
        pool[i+4] = s_val[i] + 1 - 2 * ($urandom % 2);
      end
      wr(16, $urandom);
      wr(17, $urandom % 4);
      for (int c = 0; c < 120; c++) begin
        cyc(1'($urandom % 4 != 0),
            ($urandom % 4 == 0) ? $urandom : pool[$urandom % 8],
            ($urandom % 4 == 0) ? $urandom : pool[$urandom % 8],
            8'(pool[$urandom % 8]),
            1'($urandom % 10 == 0), "R8");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule